// File: doc/BRIEF.md
# Tightly-Coupled Memory Region Decoder

This block sits on one side of a processor's level-one memory system, instruction or data. It compares each request address against the tightly-coupled memory regions configured for that side. It reports whether the access lands in a TCM and, if so, in which one. It also produces the word index into the single RAM that backs the TCMs. The decision is made in the same cycle as the request, so the RAM can be enabled at once and the cache path can be skipped.

The total size for the side is fixed at build time. A zero size gives no TCM. A 4KB size gives one TCM. Any larger size gives two TCMs, each half that size, sharing one RAM: the first TCM uses the lower half of the index range and the second uses the upper half.

Each TCM has three settings of its own: a movable, size-aligned base, an enable and a security attribute. All three are written through a small register-write port. A selection register chooses which TCM a write reaches. Only a Secure-state write may change a security attribute. A Non-secure request that lands in a Secure TCM is blocked from the RAM and flagged as a fault.

Top module: `tcm_region_decoder`

## Requirements
- R1: Parameter SIZE_KB takes one of 0, 4, 8, 16, 32 or 64. With 0, `hit`, `ram_en` and `sec_fault` stay 0 for every request.
- R2: With SIZE_KB=4 there is one 4KB TCM. On a hit, `bank` is 0 and `ram_idx` is address bits [11:2].
- R3: With SIZE_KB above 4 there are two TCMs, each SIZE_KB/2 kilobytes, with OFF_W = log2 of that size in bytes. On a hit, `ram_idx` = {bank, address[OFF_W-1:2]}, so the first TCM (bank 0) fills the lower half of the RAM and the second TCM (bank 1) fills the upper half.
- R4: A request hits a TCM only when `req_valid` is 1, the TCM is enabled, and the address lies in [base, base + TCM size). With `req_valid` at 0, every output flag is 0.
- R5: A base write keeps only address bits [ADDR_W-1:OFF_W] of `cfg_wdata`. Lower bits are dropped, so every base is aligned to its TCM size.
- R6: Every enable resets to 0, and a disabled TCM never hits.
- R7: After reset, every TCM is Secure.
- R8: A security write with `cfg_secure` at 0 is ignored, and the attribute keeps its value.
- R9: The `cfg_addr` codes are 0 = selection (`cfg_wdata[0]` picks TCM 0 or 1), 1 = region (`cfg_wdata[ADDR_W-1:OFF_W]` is the base and `cfg_wdata[0]` the enable), and 2 = security (`cfg_wdata[0]` = 1 marks the TCM Non-secure). Region and security writes reach only the selected TCM, and they are dropped when that TCM does not exist. Writes take effect at the clock edge.
- R10: A request with `req_ns` at 1 that hits a Secure TCM gives `hit`=1, `ram_en`=0 and `sec_fault`=1. A Secure request, or a Non-secure request to a Non-secure TCM, gives `ram_en`=1 and `sec_fault`=0.
- R11: When both TCMs cover the address, the first TCM wins: `bank`=0, and its security attribute applies.
- R12: `hit`, `ram_en`, `bank`, `ram_idx` and `sec_fault` follow the request combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register code |
| cfg_wdata | input | ADDR_W | Configuration write data |
| cfg_secure | input | 1 | Write issued from Secure state |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_ns | input | 1 | Request is Non-secure |
| hit | output | 1 | Address lies in an enabled TCM |
| ram_en | output | 1 | Access allowed to the RAM |
| ram_idx | output | IDX_W | Word index into the shared RAM |
| bank | output | 1 | Which TCM was hit |
| sec_fault | output | 1 | Non-secure request hit a Secure TCM |

## Verification
The hardest situation to reach is two TCMs that overlap but carry different security attributes, where the priority decides both the bank and whether a fault is raised. The bench first tries Non-secure security writes and confirms at the ports that they change nothing. It then moves the second TCM onto the first TCM's base. It probes that address with both Secure and Non-secure requests, disables the first TCM, and probes again, so the second TCM's Secure attribute becomes visible.

// File: rtl/tcm_dec_pkg.sv
package tcm_dec_pkg;

  typedef enum logic [1:0] {
    CFG_SELECT   = 2'd0,
    CFG_REGION   = 2'd1,
    CFG_SECURITY = 2'd2
  } cfg_reg_e;

  // number of TCMs produced by a side size in kilobytes
  function automatic int tcm_count(input int size_kb);
    if (size_kb == 0) return 0;
    if (size_kb == 4) return 1;
    return 2;
  endfunction

  // bytes per TCM; an empty side keeps a harmless 4KB placeholder
  function automatic int tcm_bytes(input int size_kb);
    if (size_kb > 4) return size_kb * 512;
    return 4096;
  endfunction

  function automatic int ram_index_width(input int size_kb);
    if (size_kb == 0) return 1;
    return $clog2(size_kb * 256);
  endfunction

endpackage

// File: rtl/tcm_cfg_regs.sv
module tcm_cfg_regs
  import tcm_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_TCM = 2,
  parameter int OFF_W   = 13,
  parameter int SLOTS   = (NUM_TCM > 0) ? NUM_TCM : 1,
  parameter int BASE_W  = ADDR_W - OFF_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [1:0]                    cfg_addr,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  input  logic                          cfg_secure,
  output logic [SLOTS-1:0][BASE_W-1:0]  base_o,
  output logic [SLOTS-1:0]              en_o,
  output logic [SLOTS-1:0]              ns_o
);

  logic                         sel_q;
  logic [SLOTS-1:0][BASE_W-1:0] base_q;
  logic [SLOTS-1:0]             en_q;
  logic [SLOTS-1:0]             ns_q;
  logic                         unused_wdata;

  assign unused_wdata = ^cfg_wdata[OFF_W-1:1];

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else if (cfg_we && cfg_addr == CFG_SELECT) sel_q <= cfg_wdata[0];
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic SLOT_ID = 1'(i);
    localparam bit   LIVE    = (i < NUM_TCM);
    logic slot_wr;
    assign slot_wr = LIVE && cfg_we && (sel_q == SLOT_ID);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[i] <= '0;
        en_q[i]   <= 1'b0;
        ns_q[i]   <= 1'b0;
      end else if (slot_wr) begin
        if (cfg_addr == CFG_REGION) begin
          base_q[i] <= cfg_wdata[ADDR_W-1:OFF_W];
          en_q[i]   <= cfg_wdata[0];
        end
        if (cfg_addr == CFG_SECURITY && cfg_secure) ns_q[i] <= cfg_wdata[0];
      end
    end
  end

  assign base_o = base_q;
  assign en_o   = en_q;
  assign ns_o   = ns_q;

  // R7: reset leaves every TCM Secure and disabled
  a_r7_reset_secure: assert property (@(posedge clk)
    rst |=> (ns_q == '0 && en_q == '0));

  // R8: a Non-secure security write leaves the attributes alone
  a_r8_ns_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_secure && cfg_addr == CFG_SECURITY) |=> $stable(ns_q));

endmodule

// File: rtl/tcm_region_match.sv
module tcm_region_match #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 13,
  parameter int BASE_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BASE_W-1:0] base,
  input  logic              en,
  output logic              in_range
);

  assign in_range = en && (addr[ADDR_W-1:OFF_W] == base);

endmodule

// File: rtl/tcm_region_decoder.sv
module tcm_region_decoder
  import tcm_dec_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_KB = 16,
  localparam int IDX_W  = ram_index_width(SIZE_KB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              cfg_secure,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_ns,
  output logic              hit,
  output logic              ram_en,
  output logic [IDX_W-1:0]  ram_idx,
  output logic              bank,
  output logic              sec_fault
);

  localparam int NUM_TCM = tcm_count(SIZE_KB);
  localparam int SLOTS   = (NUM_TCM > 0) ? NUM_TCM : 1;
  localparam int OFF_W   = $clog2(tcm_bytes(SIZE_KB));
  localparam int BASE_W  = ADDR_W - OFF_W;

  logic [SLOTS-1:0][BASE_W-1:0] base_w;
  logic [SLOTS-1:0]             en_w;
  logic [SLOTS-1:0]             ns_w;
  logic [SLOTS-1:0]             m_hit;
  logic                         bank_w;
  logic                         tcm_ns_w;
  logic                         unused_addr;

  assign unused_addr = ^req_addr[1:0];

  tcm_cfg_regs #(
    .ADDR_W (ADDR_W),
    .NUM_TCM(NUM_TCM),
    .OFF_W  (OFF_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_secure(cfg_secure),
    .base_o    (base_w),
    .en_o      (en_w),
    .ns_o      (ns_w)
  );

  for (genvar i = 0; i < SLOTS; i++) begin : g_match
    logic in_r;
    tcm_region_match #(
      .ADDR_W(ADDR_W),
      .OFF_W (OFF_W)
    ) match_i (
      .addr    (req_addr),
      .base    (base_w[i]),
      .en      (en_w[i]),
      .in_range(in_r)
    );
    assign m_hit[i] = (i < NUM_TCM) && in_r;
  end

  if (NUM_TCM == 2) begin : g_two
    // first TCM wins on overlap
    assign bank_w   = !m_hit[0];
    assign tcm_ns_w = m_hit[0] ? ns_w[0] : ns_w[SLOTS-1];
    assign ram_idx  = {bank_w, req_addr[OFF_W-1:2]};

    // R11: bank 1 is reported only when TCM0 does not cover the address
    a_r11_tcm0_priority: assert property (@(posedge clk) disable iff (rst)
      (hit && bank) |-> !m_hit[0]);
  end else if (NUM_TCM == 1) begin : g_one
    assign bank_w   = 1'b0;
    assign tcm_ns_w = ns_w[0];
    assign ram_idx  = req_addr[OFF_W-1:2];
  end else begin : g_none
    assign bank_w   = 1'b0;
    assign tcm_ns_w = 1'b0;
    assign ram_idx  = '0;

    // R1: an empty side never hits
    a_r1_empty_side: assert property (@(posedge clk) disable iff (rst)
      req_valid |-> !hit);
  end

  assign hit       = req_valid && (|m_hit);
  assign bank      = hit && bank_w;
  assign sec_fault = hit && req_ns && !tcm_ns_w;
  assign ram_en    = hit && !sec_fault;

  // R4: idle requests raise nothing
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (!hit && !ram_en && !sec_fault));

  // R10: a fault comes only from a Non-secure hit and blocks the RAM
  a_r10_fault_blocks_ram: assert property (@(posedge clk) disable iff (rst)
    sec_fault |-> (hit && req_ns && !ram_en));

endmodule

// File: tb/tcm_region_decoder_tb.sv
module tcm_region_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_secure = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        req_ns = 1'b0;

  logic        hit16, en16, bank16, flt16;
  logic [11:0] idx16;
  logic        hit4, en4, bank4, flt4;
  logic [9:0]  idx4;
  logic        hit0, en0, bank0, flt0;
  logic [0:0]  idx0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  tcm_region_decoder #(.ADDR_W(32), .SIZE_KB(16)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_secure(cfg_secure), .req_valid(req_valid), .req_addr(req_addr), .req_ns(req_ns),
    .hit(hit16), .ram_en(en16), .ram_idx(idx16), .bank(bank16), .sec_fault(flt16));

  tcm_region_decoder #(.ADDR_W(32), .SIZE_KB(4)) dut_4k (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_secure(cfg_secure), .req_valid(req_valid), .req_addr(req_addr), .req_ns(req_ns),
    .hit(hit4), .ram_en(en4), .ram_idx(idx4), .bank(bank4), .sec_fault(flt4));

  tcm_region_decoder #(.ADDR_W(32), .SIZE_KB(0)) dut_0k (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_secure(cfg_secure), .req_valid(req_valid), .req_addr(req_addr), .req_ns(req_ns),
    .hit(hit0), .ram_en(en0), .ram_idx(idx0), .bank(bank0), .sec_fault(flt0));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [31:0] d, input logic sec);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_secure = sec;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic ns, input logic v = 1'b1);
    @(negedge clk);
    req_valid = v; req_addr = a; req_ns = ns;
    #1;
  endtask

  // expected flags packed as {hit, ram_en, bank, sec_fault}
  task automatic exp16(input string req, input logic [3:0] f, input logic [11:0] idx);
    chk(req, {28'd0, hit16, en16, bank16, flt16}, {28'd0, f});
    if (f[3]) chk(req, {20'd0, idx16}, {20'd0, idx});
  endtask

  task automatic exp4(input string req, input logic [3:0] f, input logic [9:0] idx);
    chk(req, {28'd0, hit4, en4, bank4, flt4}, {28'd0, f});
    if (f[3]) chk(req, {22'd0, idx4}, {22'd0, idx});
  endtask

  task automatic exp0(input string req);
    chk(req, {29'd0, hit0, en0, flt0}, 32'd0);
  endtask

  task automatic t_reset;
    access(32'h0000_0000, 1'b0);
    exp16("R6 reset disabled", 4'b0000, '0);
    exp4("R6 reset disabled 4k", 4'b0000, '0);
    access(32'h0001_0000, 1'b0);
    exp16("R6 reset disabled", 4'b0000, '0);
    exp0("R1 empty side");
  endtask

  task automatic t_program;
    cfg_write(2'd0, 32'h0, 1'b1);
    cfg_write(2'd1, 32'h0001_0001, 1'b1);
    cfg_write(2'd2, 32'h1, 1'b1);
    cfg_write(2'd0, 32'h1, 1'b1);
    cfg_write(2'd1, 32'h0002_0001, 1'b1);
  endtask

  task automatic t_decode;
    access(32'h0001_0004, 1'b0);
    exp16("R3 tcm0 lower half", 4'b1100, 12'h001);
    exp4("R2 single tcm", 4'b1100, 10'h001);
    exp0("R1 empty side");
    access(32'h0001_1FFC, 1'b0);
    exp16("R4 last word tcm0", 4'b1100, 12'h7FF);
    exp4("R2 outside 4KB", 4'b0000, '0);
    access(32'h0001_2000, 1'b0);
    exp16("R4 just past tcm0", 4'b0000, '0);
    access(32'h0002_0008, 1'b0);
    exp16("R3 tcm1 upper half", 4'b1110, 12'h802);
    exp4("R9 sel1 dropped on 4k", 4'b0000, '0);
    exp0("R1 empty side");
  endtask

  task automatic t_security;
    access(32'h0002_0008, 1'b1);
    exp16("R7 tcm1 secure after reset", 4'b1011, 12'h802);
    access(32'h0001_0004, 1'b1);
    exp16("R10 ns to ns tcm0", 4'b1100, 12'h001);
    cfg_write(2'd0, 32'h1, 1'b0);
    cfg_write(2'd2, 32'h1, 1'b0);
    access(32'h0002_0008, 1'b1);
    exp16("R8 ns write ignored tcm1", 4'b1011, 12'h802);
    cfg_write(2'd0, 32'h0, 1'b0);
    cfg_write(2'd2, 32'h0, 1'b0);
    access(32'h0001_0004, 1'b1);
    exp16("R8 ns write ignored tcm0", 4'b1100, 12'h001);
    exp4("R8 ns write ignored 4k", 4'b1100, 10'h001);
  endtask

  task automatic t_align;
    cfg_write(2'd0, 32'h0, 1'b1);
    cfg_write(2'd1, 32'h0001_1FFF, 1'b1);
    access(32'h0001_0000, 1'b0);
    exp16("R5 low base bits dropped", 4'b1100, 12'h000);
    exp4("R5 4k base 0x11000", 4'b0000, '0);
    access(32'h0001_1000, 1'b0);
    exp16("R5 inside tcm0", 4'b1100, 12'h400);
    exp4("R5 4k aligned hit", 4'b1100, 10'h000);
  endtask

  task automatic t_overlap;
    cfg_write(2'd0, 32'h1, 1'b1);
    cfg_write(2'd1, 32'h0001_0001, 1'b1);
    access(32'h0001_0004, 1'b0);
    exp16("R11 tcm0 wins", 4'b1100, 12'h001);
    access(32'h0001_0004, 1'b1);
    exp16("R11 tcm0 attribute applies", 4'b1100, 12'h001);
    cfg_write(2'd0, 32'h0, 1'b1);
    cfg_write(2'd1, 32'h0001_0000, 1'b1);
    access(32'h0001_0004, 1'b0);
    exp16("R6 disabled tcm0 falls to tcm1", 4'b1110, 12'h801);
    exp4("R6 disabled 4k", 4'b0000, '0);
    access(32'h0001_0004, 1'b1);
    exp16("R10 ns hits secure tcm1", 4'b1011, 12'h801);
  endtask

  task automatic t_idle;
    access(32'h0001_0004, 1'b1, 1'b0);
    exp16("R4 no request", 4'b0000, '0);
    exp4("R4 no request 4k", 4'b0000, '0);
    exp0("R4 no request empty");
    access(32'h0001_0004, 1'b0);
    exp16("R12 same-cycle response", 4'b1110, 12'h801);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_decode();
    t_security();
    t_align();
    t_overlap();
    t_idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule